// File: doc/BRIEF.md
# Three-Key Combination Lock Controller

This block watches a two-symbol keypad and opens a lock when the presses B, A, B arrive in that order. Each clock cycle carries at most one press: a press-valid strobe plus two key lines, already synchronous to the clock. The block is a Moore machine with six legal states. Its outputs are an unlock pulse one cycle wide and a two-bit count of the keys entered in the current attempt, which a display can show.

A wrong key does not restart the attempt. The machine moves onto a parallel path of failure states that still count presses. Every attempt therefore takes three keys, and the display never reveals which key was wrong. The state register uses a fixed 3-bit code. The count and the unlock pulse come from registers that load the decoded next state. They change on the same edge as the state.

Top module: `combo_lock`

## Requirements
- R1: When `rst` is high at a rising edge, the block goes to idle. From the next cycle `key_count` is 0 and `unlock` is 0. Reset wins over a press sampled at the same edge, and a reset in the middle of an attempt discards that attempt.
- R2: A press is any cycle with `key_vld`=1. Key A is `key_a`=1, `key_b`=0. Key B is `key_a`=0, `key_b`=1. With `key_vld`=1, the patterns 00 and 11 on {`key_a`,`key_b`} still count as a press but match neither key. With `key_vld`=0 the key lines are ignored.
- R3: A cycle without a press leaves `key_count` and `unlock` unchanged in every state except the open state.
- R4: The presses B, A, B, with any number of idle cycles between them, give `key_count` values 1, 2, 3. Each output changes in the cycle after the edge that samples the press. `unlock` is 1 exactly when `key_count` is 3.
- R5: A wrong first key still advances `key_count` to 1 and then to 2. The third press returns the count to 0, and `unlock` stays 0.
- R6: A correct first key followed by a wrong second key gives counts 1 and 2. The third press returns the count to 0, whatever that key is.
- R7: A wrong third key after a correct B, A returns `key_count` to 0 with no unlock pulse.
- R8: The open state lasts exactly one cycle and then returns to idle. A press sampled during that cycle is discarded and does not count toward the next attempt.
- R9: A key held for several cycles counts as one press per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_vld | input | 1 | A press is present this cycle |
| key_a | input | 1 | Key line for symbol A |
| key_b | input | 1 | Key line for symbol B |
| unlock | output | 1 | One-cycle open pulse |
| key_count | output | 2 | Keys entered in the current attempt (0 to 3) |

## Verification
The only places internal state shows are the count and the pulse. A state register that has taken a wrong branch shows up on `key_count` in the cycle after the faulty press, or at the latest when the third press should return the count to 0 or 3. Confusing the good and bad paths changes nothing visible until the third key, so the bench finishes every attempt and compares the outcome in that cycle. Each result is checked one cycle after the press that caused it, so a one-cycle timing slip counts as a mismatch.

// File: rtl/combo_lock_pkg.sv
package combo_lock_pkg;

  localparam int STATE_W = 3;
  localparam int COUNT_W = 2;
  localparam int SEQ_LEN = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 3'b000,
    ST_OK1  = 3'b001,
    ST_OK2  = 3'b010,
    ST_OPEN = 3'b011,
    ST_BAD1 = 3'b100,
    ST_BAD2 = 3'b101
  } lock_state_e;

  typedef enum logic [1:0] {
    SYM_NONE = 2'd0,
    SYM_A    = 2'd1,
    SYM_B    = 2'd2,
    SYM_ODD  = 2'd3
  } key_sym_e;

  localparam key_sym_e CODE_FIRST  = SYM_B;
  localparam key_sym_e CODE_SECOND = SYM_A;
  localparam key_sym_e CODE_THIRD  = SYM_B;

endpackage

// File: rtl/combo_lock_keydec.sv
module combo_lock_keydec
  import combo_lock_pkg::*;
(
  input  logic     key_vld,
  input  logic     key_a,
  input  logic     key_b,
  output key_sym_e sym
);

  always_comb begin
    if (!key_vld)              sym = SYM_NONE;
    else if (key_a && !key_b)  sym = SYM_A;
    else if (!key_a && key_b)  sym = SYM_B;
    else                       sym = SYM_ODD;
  end

endmodule

// File: rtl/combo_lock_next.sv
module combo_lock_next
  import combo_lock_pkg::*;
(
  input  logic [STATE_W-1:0] cur,
  input  key_sym_e           sym,
  output logic [STATE_W-1:0] nxt
);

  logic pressed;
  assign pressed = (sym != SYM_NONE);

  always_comb begin
    nxt = cur;
    case (cur)
      ST_IDLE: if (pressed) nxt = (sym == CODE_FIRST)  ? ST_OK1  : ST_BAD1;
      ST_OK1:  if (pressed) nxt = (sym == CODE_SECOND) ? ST_OK2  : ST_BAD2;
      ST_OK2:  if (pressed) nxt = (sym == CODE_THIRD)  ? ST_OPEN : ST_IDLE;
      ST_OPEN: nxt = ST_IDLE;
      ST_BAD1: if (pressed) nxt = ST_BAD2;
      ST_BAD2: if (pressed) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/combo_lock_view.sv
module combo_lock_view
  import combo_lock_pkg::*;
(
  input  logic [STATE_W-1:0] st,
  output logic [COUNT_W-1:0] count,
  output logic               open
);

  always_comb begin
    count = '0;
    open  = 1'b0;
    case (st)
      ST_OK1, ST_BAD1: count = COUNT_W'(1);
      ST_OK2, ST_BAD2: count = COUNT_W'(2);
      ST_OPEN: begin
        count = COUNT_W'(SEQ_LEN);
        open  = 1'b1;
      end
      default: count = '0;
    endcase
  end

endmodule

// File: rtl/combo_lock.sv
module combo_lock
  import combo_lock_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               key_vld,
  input  logic               key_a,
  input  logic               key_b,
  output logic               unlock,
  output logic [COUNT_W-1:0] key_count
);

  key_sym_e           sym;
  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] state_d;
  logic [COUNT_W-1:0] count_d;
  logic               open_d;

  combo_lock_keydec u_keydec (
    .key_vld (key_vld),
    .key_a   (key_a),
    .key_b   (key_b),
    .sym     (sym)
  );

  combo_lock_next u_next (
    .cur (state_q),
    .sym (sym),
    .nxt (state_d)
  );

  combo_lock_view u_view (
    .st    (state_d),
    .count (count_d),
    .open  (open_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      key_count <= '0;
      unlock    <= 1'b0;
    end else begin
      state_q   <= state_d;
      key_count <= count_d;
      unlock    <= open_d;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (key_count == '0) && !unlock); // R1

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (state_q != 3'b110) && (state_q != 3'b111)); // R1

  AST_HOLD_NO_KEY: assert property (@(posedge clk) disable iff (rst)
    (!key_vld && !unlock) |=> $stable(key_count) && !unlock); // R3

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (key_vld && (key_count < COUNT_W'(2))) |=>
      (key_count == $past(key_count) + COUNT_W'(1))); // R5

  AST_UNLOCK_ON_B: assert property (@(posedge clk) disable iff (rst)
    $rose(unlock) |-> ($past(key_vld) && $past(key_b) && !$past(key_a))); // R4

  AST_UNLOCK_PULSE: assert property (@(posedge clk) disable iff (rst)
    unlock |=> !unlock && (key_count == '0)); // R8

endmodule

// File: tb/combo_lock_bench.sv
`timescale 1ns/1ps
module combo_lock_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       key_vld = 1'b0;
  logic       key_a = 1'b0;
  logic       key_b = 1'b0;
  logic       unlock;
  logic [1:0] key_count;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [2:0] exp_q[$];
  string      tag_q[$];

  // reference model: presses so far, all correct so far, open flag
  int m_cnt = 0;
  bit m_ok = 1'b1;
  bit m_open = 1'b0;

  always #2.5 clk = ~clk;

  combo_lock u_combo_lock (
    .clk       (clk),
    .rst       (rst),
    .key_vld   (key_vld),
    .key_a     (key_a),
    .key_b     (key_b),
    .unlock    (unlock),
    .key_count (key_count)
  );

  // symbols: 1=A, 2=B, 3=neither
  function automatic int code_at(int idx);
    return (idx == 1) ? 1 : 2;
  endfunction

  task automatic step(input bit r, input bit v, input bit a, input bit b, input string tag);
    int sym;
    bit hit;
    @(negedge clk);
    rst = r; key_vld = v; key_a = a; key_b = b;
    sym = (a && !b) ? 1 : (!a && b) ? 2 : 3;
    if (r) begin
      m_cnt = 0; m_ok = 1'b1; m_open = 1'b0;
    end else if (m_open) begin
      m_open = 1'b0; m_cnt = 0; m_ok = 1'b1;
    end else if (v) begin
      hit = m_ok && (sym == code_at(m_cnt));
      if (m_cnt + 1 == 3) begin
        m_ok = 1'b1;
        if (hit) begin m_open = 1'b1; m_cnt = 3; end
        else m_cnt = 0;
      end else begin
        m_cnt = m_cnt + 1;
        m_ok = hit;
      end
    end
    exp_q.push_back({m_open, 2'(m_cnt)});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, i[0], ~i[0], tag);
  endtask

  task automatic key(input int s, input string tag);
    step(1'b0, 1'b1, (s == 1) || (s == 3), (s == 2) || (s == 3), tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        compared++;
        if ({unlock, key_count} !== e) begin
          mismatched++;
          $display("FAIL %s: actual unlock=%0b count=%0d expected unlock=%0b count=%0d",
                   t, unlock, key_count, e[2], e[1:0]);
        end
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      mismatched++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R1 reset state, press ignored during reset
    step(1'b1, 1'b0, 1'b0, 1'b0, "R1 reset");
    step(1'b1, 1'b1, 1'b0, 1'b1, "R1 reset beats press");
    // R2 R3 key lines ignored without strobe
    idle(4, "R2 R3 no strobe");
    // R4 correct code with gaps
    key(2, "R4 first B");
    idle(2, "R3 hold at 1");
    key(1, "R4 second A");
    idle(3, "R3 hold at 2");
    key(2, "R4 third B opens");
    idle(2, "R8 open ends");
    // R4 back-to-back, R8 press during open discarded
    key(2, "R4 b2b B");
    key(1, "R4 b2b A");
    key(2, "R4 b2b B opens");
    key(2, "R8 press in open dropped");
    key(2, "R8 new attempt B");
    key(1, "R8 new attempt A");
    key(2, "R8 new attempt opens");
    idle(1, "R8 back to idle");
    // R5 wrong first key
    key(1, "R5 wrong first");
    key(2, "R5 bad second");
    idle(1, "R3 hold bad");
    key(2, "R5 bad third");
    idle(1, "R5 stays idle");
    // R2 odd patterns count as presses
    key(3, "R2 both lines");
    step(1'b0, 1'b1, 1'b0, 1'b0, "R2 no line");
    key(2, "R2 third ends");
    // R6 wrong second key
    key(2, "R6 first B");
    key(2, "R6 wrong second");
    key(1, "R6 third ends");
    // R7 wrong third key
    key(2, "R7 first");
    key(1, "R7 second");
    key(1, "R7 wrong third");
    key(2, "R7 again B");
    key(1, "R7 again A");
    key(3, "R7 odd third");
    // R9 held key
    key(2, "R9 held 1");
    key(2, "R9 held 2");
    key(2, "R9 held 3");
    idle(1, "R9 idle");
    // R1 reset mid-attempt
    key(2, "R1 pre B");
    key(1, "R1 pre A");
    step(1'b1, 1'b1, 1'b0, 1'b1, "R1 mid reset");
    key(2, "R1 after reset B");
    key(1, "R1 after reset A");
    key(2, "R1 after reset opens");
    idle(3, "R8 tail");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule